// File: doc/BRIEF.md
# SDRAM Presence-Detect Image Builder

This block turns a requested memory technology and capacity into a 256-byte presence-detect image, held in an internal RAM that the surrounding logic reads one byte at a time. A single-cycle `start` captures a technology code and a capacity in MiB. The block then works out a legal geometry: it rounds the capacity down to a power of two, moves to another technology if the capacity is too small for the one requested, spreads the capacity over up to eight banks and packs a per-technology density byte. It then writes the whole image in one pass of one byte per clock, with byte 63 carrying the running checksum.

Warnings report capacities that were rounded, technologies that were swapped and capacities that could not be fully represented. An error reports an unusable request. In that case the pass still runs but writes only zeros. All flags and the resulting technology code stay valid from the cycle after `start` until the next accepted `start`.

Top module: `spd_image_gen`

## Requirements
- R1: After reset, `busy`, `done`, `err_flag`, `warn_round`, `warn_retype`, `warn_trunc` are 0 and `type_out` is 0.
- R2: `start` is accepted only while `busy` is 0. `busy` is 1 for the 256 cycles after the accepting edge. `done` is 1 for exactly one cycle, the cycle after the last byte is written, and `busy` is 0 in that cycle. A `start` seen while `busy` is 1 changes nothing.
- R3: A technology code other than 4 (SDR), 7 (DDR) or 8 (DDR2), or a capacity below 4 MiB, sets `err_flag`, clears every warning and `type_out`, and the pass writes 0 to all 256 bytes.
- R4: The capacity is rounded down to 2^L, where L is the index of its highest set bit. `warn_round` is set when any lower bit was 1.
- R5: L must lie in 2..9 for SDR, 5..12 for DDR and 7..14 for DDR2. If L is below the minimum, `warn_retype` is set and the technology becomes DDR when L≥5, SDR otherwise. `type_out` and byte 2 carry the final code.
- R6: Starting at one bank, while L exceeds the maximum and fewer than 8 banks are used, L drops by one and the bank count rises by one. `warn_trunc` is set when 2^L times the bank count is below the rounded capacity.
- R7: If one bank remains and L is above the minimum, L drops by one more and the bank count becomes 2.
- R8: Byte 31 holds D = 2^(L−2) packed per technology. DDR2: D[7:5] in bits 7:5 and D[12:8] in bits 4:0. DDR: D[7:3] in bits 7:3 and D[10:8] in bits 2:0. SDR: D[7:0].
- R9: Byte 5 is the bank count, minus one for DDR2. Bytes 15 and 19 are 0 for DDR2 and 1 otherwise.
- R10: The constant bytes are 0:128, 1:8, 3:13, 4:10, 6:64, 8:4, 9:0x25, 10:1, 12:0x82, 13:8, 16:12, 17:4, 18:12, 20:2, 23:0x12, 27:20, 28:15, 29:20, 30:45, 32:20, 33:8, 34:20, 35:8. Every byte not named in R5, R8, R9, R10 or R11 is 0, including all bytes from 64 to 255.
- R11: Byte 63 is the sum of bytes 0 to 62, modulo 256.
- R12: `rd_data` shows the byte at `rd_addr` as sampled on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, accepted when idle |
| type_code | input | 4 | Requested technology: 4 SDR, 7 DDR, 8 DDR2 |
| size_mib | input | SIZE_W | Requested capacity in MiB |
| rd_addr | input | 8 | Image byte address to read |
| rd_data | output | 8 | Image byte, one cycle after address |
| busy | output | 1 | Image pass in progress |
| done | output | 1 | One-cycle completion pulse |
| type_out | output | 4 | Final technology code, 0 on error |
| err_flag | output | 1 | Request unusable |
| warn_round | output | 1 | Capacity was not a power of two |
| warn_retype | output | 1 | Technology changed to fit capacity |
| warn_trunc | output | 1 | Capacity exceeds eight-bank layout |

## Verification
The bench targets the geometry edges. These are capacities exactly at a technology's maximum exponent, one step beyond it, and far beyond it, where greedy splitting leaves a shortfall. A design that decrements the exponent once too often, or checks the shortfall against the unrounded capacity, reports the wrong bank count in byte 5 or the wrong truncation flag. DDR2 and DDR requests too small for their range must fall back to DDR or SDR on the 32 MiB boundary. Densities above 255 must land in the folded low bits of byte 31, where a plain truncation yields 0. The bench also sends a second `start` in the middle of a pass and tries illegal codes and sub-4 MiB sizes. A design that rearms on that `start` or leaves stale bytes behind shows a shifted `done` or a nonzero byte.

// File: rtl/spd_pkg.sv
package spd_pkg;
  localparam logic [3:0] KIND_SDR  = 4'd4;
  localparam logic [3:0] KIND_DDR  = 4'd7;
  localparam logic [3:0] KIND_DDR2 = 4'd8;
  localparam int         CSUM_IDX  = 63;

  typedef struct packed {
    logic       err;
    logic       w_round;
    logic       w_retype;
    logic       w_trunc;
    logic [3:0] kind;
    logic [3:0] banks;
    logic [7:0] dens;
  } geom_t;
endpackage

// File: rtl/spd_geom.sv
module spd_geom #(
  parameter int SIZE_W = 16
) (
  input  logic [3:0]        type_code,
  input  logic [SIZE_W-1:0] size_mib,
  output spd_pkg::geom_t    geom
);
  import spd_pkg::*;

  always_comb begin
    int l, orig, lo, hi, nb;
    logic legal;
    logic [SIZE_W-1:0] rounded;
    logic [31:0] d;
    logic [3:0] kind;

    geom = '0;
    l = 0;
    for (int i = 0; i < SIZE_W; i++) begin
      if (size_mib[i]) l = i;
    end
    orig = l;
    rounded = '0;
    rounded[l] = 1'b1;

    kind  = type_code;
    legal = 1'b1;
    lo = 2; hi = 9;
    case (type_code)
      KIND_SDR:  begin lo = 2; hi = 9;  end
      KIND_DDR:  begin lo = 5; hi = 12; end
      KIND_DDR2: begin lo = 7; hi = 14; end
      default:   legal = 1'b0;
    endcase

    if (l < lo) begin
      geom.w_retype = 1'b1;
      if (l >= 5) begin kind = KIND_DDR; lo = 5; hi = 12; end
      else        begin kind = KIND_SDR; lo = 2; hi = 9;  end
    end

    nb = 1;
    for (int k = 0; k < 7; k++) begin
      if (l > hi) begin
        l  = l - 1;
        nb = nb + 1;
      end
    end
    // 2^(orig-s)*(1+s) falls short of 2^orig exactly when s >= 2
    geom.w_trunc = ((orig - l) >= 2);

    if (nb == 1 && l > lo) begin
      l  = l - 1;
      nb = 2;
    end

    d = 32'd1 << (l - 2);
    if (kind == KIND_DDR2)     geom.dens = {d[7:5], d[12:8]};
    else if (kind == KIND_DDR) geom.dens = {d[7:3], d[10:8]};
    else                       geom.dens = d[7:0];

    geom.kind    = kind;
    geom.banks   = 4'(nb);
    geom.w_round = (size_mib != rounded);

    if (!legal || size_mib < SIZE_W'(4)) begin
      geom     = '0;
      geom.err = 1'b1;
    end
  end
endmodule

// File: rtl/spd_byte_gen.sv
module spd_byte_gen (
  input  logic [7:0] idx,
  input  logic       blank,
  input  logic [3:0] kind,
  input  logic [3:0] banks,
  input  logic [7:0] dens,
  input  logic [7:0] csum,
  output logic [7:0] val
);
  import spd_pkg::*;

  logic is_ddr2;
  assign is_ddr2 = (kind == KIND_DDR2);

  always_comb begin
    val = 8'h00;
    if (!blank) begin
      case (idx)
        8'd0:  val = 8'd128;
        8'd1:  val = 8'd8;
        8'd2:  val = {4'h0, kind};
        8'd3:  val = 8'd13;
        8'd4:  val = 8'd10;
        8'd5:  val = {4'h0, is_ddr2 ? banks - 4'd1 : banks};
        8'd6:  val = 8'd64;
        8'd8:  val = 8'd4;
        8'd9:  val = 8'h25;
        8'd10: val = 8'd1;
        8'd12: val = 8'h82;
        8'd13: val = 8'd8;
        8'd15: val = is_ddr2 ? 8'd0 : 8'd1;
        8'd16: val = 8'd12;
        8'd17: val = 8'd4;
        8'd18: val = 8'd12;
        8'd19: val = is_ddr2 ? 8'd0 : 8'd1;
        8'd20: val = 8'd2;
        8'd23: val = 8'h12;
        8'd27: val = 8'd20;
        8'd28: val = 8'd15;
        8'd29: val = 8'd20;
        8'd30: val = 8'd45;
        8'd31: val = dens;
        8'd32: val = 8'd20;
        8'd33: val = 8'd8;
        8'd34: val = 8'd20;
        8'd35: val = 8'd8;
        8'd63: val = csum;
        default: val = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/spd_img_ram.sv
module spd_img_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spd_image_gen.sv
module spd_image_gen #(
  parameter int SIZE_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [3:0]        type_code,
  input  logic [SIZE_W-1:0] size_mib,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              done,
  output logic [3:0]        type_out,
  output logic              err_flag,
  output logic              warn_round,
  output logic              warn_retype,
  output logic              warn_trunc
);
  import spd_pkg::*;

  localparam int IMG_BYTES = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(IMG_BYTES - 1);
  localparam logic [ADDR_W-1:0] SUM_END  = ADDR_W'(CSUM_IDX);

  typedef enum logic {S_IDLE, S_FILL} state_e;

  state_e            state;
  logic [ADDR_W-1:0] idx;
  logic [7:0]        csum;
  geom_t             g_now, g_q;
  logic [7:0]        wbyte;

  spd_geom #(.SIZE_W(SIZE_W)) u_geom (
    .type_code (type_code),
    .size_mib  (size_mib),
    .geom      (g_now)
  );

  spd_byte_gen u_bytes (
    .idx   (8'(idx)),
    .blank (g_q.err),
    .kind  (g_q.kind),
    .banks (g_q.banks),
    .dens  (g_q.dens),
    .csum  (csum),
    .val   (wbyte)
  );

  spd_img_ram #(.ADDR_W(ADDR_W), .DATA_W(8)) u_ram (
    .clk   (clk),
    .we    (state == S_FILL),
    .waddr (idx),
    .wdata (wbyte),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      idx   <= '0;
      csum  <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
      g_q   <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            g_q   <= g_now;
            idx   <= '0;
            csum  <= '0;
            busy  <= 1'b1;
            state <= S_FILL;
          end
        end
        S_FILL: begin
          if (idx < SUM_END) csum <= csum + wbyte;
          idx <= idx + 1'b1;
          if (idx == LAST_IDX) begin
            state <= S_IDLE;
            busy  <= 1'b0;
            done  <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign type_out    = g_q.kind;
  assign err_flag    = g_q.err;
  assign warn_round  = g_q.w_round;
  assign warn_retype = g_q.w_retype;
  assign warn_trunc  = g_q.w_trunc;
endmodule

// File: rtl/spd_image_chk.sv
module spd_image_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [3:0] type_out,
  input logic       err_flag,
  input logic       warn_round,
  input logic       warn_retype,
  input logic       warn_trunc
);
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_busy_from_start_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  p_flags_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable({type_out, err_flag, warn_round, warn_retype, warn_trunc}));

  p_err_clears_r3: assert property (@(posedge clk) disable iff (rst)
    err_flag |-> (type_out == 4'd0 && !warn_round && !warn_retype && !warn_trunc));

  p_type_legal_r5: assert property (@(posedge clk) disable iff (rst)
    (done && !err_flag) |-> (type_out == 4'd4 || type_out == 4'd7 || type_out == 4'd8));
endmodule

bind spd_image_gen spd_image_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .type_out    (type_out),
  .err_flag    (err_flag),
  .warn_round  (warn_round),
  .warn_retype (warn_retype),
  .warn_trunc  (warn_trunc)
);

// File: tb/sim_spd_image_gen.sv
module sim_spd_image_gen;
  logic        clk = 0;
  logic        rst = 1;
  logic        start = 0;
  logic [3:0]  type_code = 0;
  logic [15:0] size_mib = 0;
  logic [7:0]  rd_addr = 0;
  logic [7:0]  rd_data;
  logic        busy, done, err_flag, warn_round, warn_retype, warn_trunc;
  logic [3:0]  type_out;

  int vecs = 0;
  int miss = 0;
  bit finished = 0;

  int exp_img [256];
  int p_err, p_round, p_retype, p_trunc, p_type;
  int c_err = 0, c_round = 0, c_retype = 0, c_trunc = 0, c_type = 0;
  int ref_busy = 0, ref_done = 0, ref_cnt = 0;

  always #5 clk = ~clk;

  spd_image_gen u0 (
    .clk(clk), .rst(rst), .start(start), .type_code(type_code),
    .size_mib(size_mib), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .done(done), .type_out(type_out), .err_flag(err_flag),
    .warn_round(warn_round), .warn_retype(warn_retype), .warn_trunc(warn_trunc)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vecs++;
    if (!ok) begin
      miss++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model of the image, from the requirements
  task automatic model(input int t, input int s);
    int l, r, lo, hi, nb, d, dens, kind, sum;
    for (int i = 0; i < 256; i++) exp_img[i] = 0;
    p_err = 0; p_round = 0; p_retype = 0; p_trunc = 0; p_type = 0;
    if (!(t == 4 || t == 7 || t == 8) || s < 4) begin
      p_err = 1;
      return;
    end
    l = 0;
    for (int i = 0; i < 32; i++) if (((s >> i) & 1) == 1) l = i;
    r = 1 << l;
    p_round = (s != r);
    kind = t;
    if (t == 4) begin lo = 2; hi = 9; end
    else if (t == 7) begin lo = 5; hi = 12; end
    else begin lo = 7; hi = 14; end
    if (l < lo) begin
      p_retype = 1;
      if (r >= 32) begin kind = 7; lo = 5; hi = 12; end
      else begin kind = 4; lo = 2; hi = 9; end
    end
    nb = 1;
    while (l > hi && nb < 8) begin l--; nb++; end
    p_trunc = (r > (1 << l) * nb);
    if (nb == 1 && l > lo) begin l--; nb = 2; end
    d = 1 << (l - 2);
    if (kind == 8)      dens = (d & 'he0) | ((d >> 8) & 'h1f);
    else if (kind == 7) dens = (d & 'hf8) | ((d >> 8) & 'h07);
    else                dens = d & 'hff;
    p_type = kind;
    exp_img[0] = 128; exp_img[1] = 8; exp_img[2] = kind; exp_img[3] = 13;
    exp_img[4] = 10; exp_img[5] = (kind == 8) ? nb - 1 : nb; exp_img[6] = 64;
    exp_img[8] = 4; exp_img[9] = 'h25; exp_img[10] = 1; exp_img[12] = 'h82;
    exp_img[13] = 8; exp_img[15] = (kind == 8) ? 0 : 1; exp_img[16] = 12;
    exp_img[17] = 4; exp_img[18] = 12; exp_img[19] = (kind == 8) ? 0 : 1;
    exp_img[20] = 2; exp_img[23] = 'h12; exp_img[27] = 20; exp_img[28] = 15;
    exp_img[29] = 20; exp_img[30] = 45; exp_img[31] = dens; exp_img[32] = 20;
    exp_img[33] = 8; exp_img[34] = 20; exp_img[35] = 8;
    sum = 0;
    for (int i = 0; i < 63; i++) sum += exp_img[i];
    exp_img[63] = sum % 256;
  endtask

  // cycle reference for handshake and flags
  always @(posedge clk) begin
    if (rst) begin
      ref_busy <= 0; ref_done <= 0; ref_cnt <= 0;
      c_err <= 0; c_round <= 0; c_retype <= 0; c_trunc <= 0; c_type <= 0;
    end else begin
      ref_done <= 0;
      if (ref_busy != 0) begin
        if (ref_cnt == 0) begin ref_busy <= 0; ref_done <= 1; end
        else ref_cnt <= ref_cnt - 1;
      end else if (start) begin
        ref_busy <= 1; ref_cnt <= 255;
        c_err <= p_err; c_round <= p_round; c_retype <= p_retype;
        c_trunc <= p_trunc; c_type <= p_type;
      end
    end
  end

  // compared every clock, away from the active edge (R1 after reset, R2 timing)
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(busy == ref_busy[0], "R2 busy", int'(busy), ref_busy);
      chk(done == ref_done[0], "R2 done", int'(done), ref_done);
      chk(err_flag == c_err[0], "R3 err_flag", int'(err_flag), c_err);
      chk(warn_round == c_round[0], "R4 warn_round", int'(warn_round), c_round);
      chk(warn_retype == c_retype[0], "R5 warn_retype", int'(warn_retype), c_retype);
      chk(warn_trunc == c_trunc[0], "R6 warn_trunc", int'(warn_trunc), c_trunc);
      chk(int'(type_out) == c_type, "R5 type_out", int'(type_out), c_type);
    end
  end

  task automatic read_image(input string what);
    string tag;
    for (int a = 0; a < 256; a++) begin
      @(negedge clk) rd_addr = 8'(a);
      @(negedge clk);
      if (p_err != 0)   tag = "R3 blank image";
      else if (a == 63) tag = "R11 checksum";
      else if (a == 31) tag = "R8 density";
      else if (a == 5 || a == 15 || a == 19) tag = "R9 bank/type byte";
      else if (a == 2)  tag = "R5 type byte";
      else tag = "R10/R12 image byte";
      chk(int'(rd_data) == exp_img[a], $sformatf("%s %s addr %0d", tag, what, a),
          int'(rd_data), exp_img[a]);
    end
  endtask

  task automatic run_case(input int t, input int s, input bit poke_busy);
    model(t, s);
    @(negedge clk);
    type_code = 4'(t); size_mib = 16'(s); start = 1;
    @(negedge clk);
    start = 0;
    if (poke_busy) begin
      repeat (20) @(negedge clk);
      type_code = 4'd7; size_mib = 16'd5; start = 1;   // R2: ignored while busy
      @(negedge clk);
      start = 0;
      repeat (240) @(negedge clk);
    end else begin
      repeat (260) @(negedge clk);
    end
    read_image($sformatf("t%0d s%0d", t, s));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state (also checked every cycle by the monitor)
    chk(busy == 0 && done == 0 && err_flag == 0 && type_out == 0, "R1 reset",
        int'({busy, done, err_flag}), 0);
    run_case(4, 64, 0);     // R7 forced split, SDR
    run_case(7, 256, 0);    // R7 DDR
    run_case(8, 1024, 1);   // R2 start during busy
    run_case(8, 100, 0);    // R4 round, R5 retype to DDR
    run_case(8, 16, 0);     // R5 retype to SDR
    run_case(4, 4096, 0);   // R6 multi-bank with truncation
    run_case(4, 1024, 0);   // R6 single step, no truncation
    run_case(8, 32768, 0);  // R8 DDR2 folded density
    run_case(7, 8192, 0);   // R8 DDR folded density
    run_case(4, 3, 0);      // R3 too small
    run_case(5, 512, 0);    // R3 bad code
    run_case(4, 4, 0);      // R4/R7 minimum size
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      miss++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end
endmodule